// File: doc/BRIEF.md
# Automatic RTS/CTS Flow Controller

This block is the per-channel hardware handshake of a 16550-style UART. On the receive side it compares the receive FIFO fill level with a trigger level chosen by a 2-bit code. It drives the active-low request-to-send output so that the far end stops sending before the FIFO overflows.

On the transmit side it passes the active-low clear-to-send input through a synchronizer. It then decides, only at character boundaries, whether the transmitter may begin the next character. A character that is already being shifted out always completes.

Both handshake directions can raise an interrupt request on a 0-to-1 change of their line. A pulse that reports a read of the modem status register clears these requests. Two status bits mirror the current line levels while automatic control is active. The FIFOs, shift registers, baud clock and register decode sit outside this block. Software sees the configuration bits at its ports.

Top module: `uart_flow_ctl`

## Requirements
- R1: During and after a synchronous active-high reset, `rts_n`=1, `tx_permit`=1, `irq_flow`=0, `stat_rts`=0 and `stat_cts`=0.
- R2: Automatic RTS is active only when both `cfg_flow_en` and `cfg_rts_req` are 1. Automatic CTS is active whenever `cfg_flow_en` is 1, even with `cfg_rts_req`=0.
- R3: With automatic RTS inactive, `rts_n` equals the inverse of `cfg_rts_req`, one clock after the input is sampled.
- R4: The trigger code `cfg_trig_sel` selects the level 00=1, 01=4, 10=8, 11=14 characters.
- R5: With automatic RTS active and `rts_n`=0, `rts_n` rises one clock after a cycle in which `rx_stop_seen`=1 and `rx_count` is at or above the trigger level. The count alone, without that stop-bit strobe, never raises it.
- R6: With automatic RTS active and `rts_n`=1, `rts_n` stays 1 while `rx_count` is at or above the trigger level. It falls one clock after a cycle in which `rx_count` is below the trigger level.
- R7: `cts_in_n` passes through a two-flop synchronizer. A change made just after a clock edge reaches `stat_cts`, `tx_permit` and the CTS interrupt on the third rising edge.
- R8: A character is in progress from a cycle with `tx_char_start`=1 until a cycle with `tx_char_done`=1. While it is in progress `tx_permit` holds. When no character is in progress, `tx_permit` is 0 exactly when automatic CTS is active and the synchronized CTS line is 1.
- R9: With automatic CTS inactive, the CTS line has no effect: `tx_permit` is 1 whenever no character is in progress.
- R10: A rise of `rts_n` caused by R5 sets a pending request, and so `irq_flow`=1, only when `irq_rts_en`=1.
- R11: A 0-to-1 change of the synchronized CTS line while `cfg_flow_en`=1 sets a pending request only when `irq_cts_en`=1.
- R12: `modem_stat_rd`=1 clears both pending requests on the next clock. If a new event arrives in the same cycle, that event's request stays set.
- R13: `stat_rts` equals `rts_n` while automatic RTS is active and is 0 otherwise. `stat_cts` equals the synchronized CTS line while `cfg_flow_en`=1 and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_flow_en | input | 1 | Automatic flow control enable |
| cfg_rts_req | input | 1 | Software request-to-send bit |
| cfg_trig_sel | input | 2 | Receive trigger level code |
| irq_rts_en | input | 1 | Enable interrupt on automatic RTS rise |
| irq_cts_en | input | 1 | Enable interrupt on CTS rise |
| rx_count | input | CNT_W | Receive FIFO fill level |
| rx_stop_seen | input | 1 | Pulse: stop bit of a received character sampled |
| tx_char_start | input | 1 | Pulse: transmitter began a character |
| tx_char_done | input | 1 | Pulse: transmitter finished a character |
| cts_in_n | input | 1 | Asynchronous clear-to-send line, active low |
| modem_stat_rd | input | 1 | Pulse: modem status register read |
| rts_n | output | 1 | Request-to-send line, active low |
| tx_permit | output | 1 | Transmitter may begin a new character |
| irq_flow | output | 1 | Flow-control interrupt request |
| stat_rts | output | 1 | Status mirror of the RTS line |
| stat_cts | output | 1 | Status mirror of the synchronized CTS line |

## Verification
The assertions take for granted that `rx_count` never exceeds the FIFO depth, that strobes last a single cycle, and that `tx_char_start` only follows a cycle in which `tx_permit` was 1. The stimulus keeps `rx_count` on a bounded walk between 0 and 16. It raises the start strobe only when the bench sees the transmitter idle and permitted, and pairs each start with exactly one done strobe a few cycles later. Directed phases set up the trigger codes, the hysteresis band, a change in the CTS line during a character, and an event that lands in the same cycle as a read. A long mixed phase is then compared every clock against the bench model.

// File: rtl/uart_flow_pkg.sv
package uart_flow_pkg;

  typedef enum logic [1:0] {
    TRIG_CODE_A = 2'b00,
    TRIG_CODE_B = 2'b01,
    TRIG_CODE_C = 2'b10,
    TRIG_CODE_D = 2'b11
  } trig_code_e;

  // Map a trigger code to its character count.
  function automatic int unsigned pick_trig(input logic [1:0] sel,
                                            input int unsigned lvl_a,
                                            input int unsigned lvl_b,
                                            input int unsigned lvl_c,
                                            input int unsigned lvl_d);
    case (trig_code_e'(sel))
      TRIG_CODE_A: return lvl_a;
      TRIG_CODE_B: return lvl_b;
      TRIG_CODE_C: return lvl_c;
      default:     return lvl_d;
    endcase
  endfunction

endpackage

// File: rtl/flow_cts_sync.sv
module flow_cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) q[0] <= 1'b0;
        else     q[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) q[i] <= 1'b0;
        else     q[i] <= q[i-1];
      end
    end
  end

  assign dout = q[STAGES-1];
endmodule

// File: rtl/flow_rts_ctrl.sv
module flow_rts_ctrl #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             auto_on,
  input  logic             rts_req,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] trig_lvl,
  input  logic             stop_seen,
  output logic             rts_n,
  output logic             rts_up,
  output logic             stat_rts
);
  logic at_trig;
  logic rts_nx;

  assign at_trig = (rx_count >= trig_lvl);

  always_comb begin
    rts_up = auto_on && !rts_n && stop_seen && at_trig;
    if (!auto_on)              rts_nx = !rts_req;
    else if (rts_up)           rts_nx = 1'b1;
    else if (rts_n && !at_trig) rts_nx = 1'b0;
    else                       rts_nx = rts_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rts_n    <= 1'b1;
      stat_rts <= 1'b0;
    end else begin
      rts_n    <= rts_nx;
      stat_rts <= auto_on && rts_nx;
    end
  end
endmodule

// File: rtl/flow_tx_gate.sv
module flow_tx_gate (
  input  logic clk,
  input  logic rst,
  input  logic cts_block,
  input  logic char_start,
  input  logic char_done,
  output logic tx_permit
);
  logic busy;
  logic busy_nx;

  assign busy_nx = char_start || (busy && !char_done);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      tx_permit <= 1'b1;
    end else begin
      busy <= busy_nx;
      // Line is looked at only on a character boundary.
      if (!busy_nx) tx_permit <= !cts_block;
    end
  end
endmodule

// File: rtl/flow_irq.sv
module flow_irq (
  input  logic clk,
  input  logic rst,
  input  logic rts_up,
  input  logic rts_ien,
  input  logic cts_line,
  input  logic cts_watch,
  input  logic cts_ien,
  input  logic stat_rd,
  output logic irq
);
  logic cts_d;
  logic pend_rts, pend_cts;
  logic pend_rts_nx, pend_cts_nx;
  logic cts_rise;

  assign cts_rise = cts_line && !cts_d;

  always_comb begin
    if (rts_up && rts_ien) pend_rts_nx = 1'b1;
    else if (stat_rd)      pend_rts_nx = 1'b0;
    else                   pend_rts_nx = pend_rts;
    if (cts_watch && cts_ien && cts_rise) pend_cts_nx = 1'b1;
    else if (stat_rd)                     pend_cts_nx = 1'b0;
    else                                  pend_cts_nx = pend_cts;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cts_d    <= 1'b0;
      pend_rts <= 1'b0;
      pend_cts <= 1'b0;
      irq      <= 1'b0;
    end else begin
      cts_d    <= cts_line;
      pend_rts <= pend_rts_nx;
      pend_cts <= pend_cts_nx;
      irq      <= pend_rts_nx || pend_cts_nx;
    end
  end
endmodule

// File: rtl/uart_flow_ctl.sv
module uart_flow_ctl #(
  parameter int FIFO_DEPTH  = 16,
  parameter int SYNC_STAGES = 2,
  parameter int TRIG_A      = 1,
  parameter int TRIG_B      = 4,
  parameter int TRIG_C      = 8,
  parameter int TRIG_D      = 14,
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_flow_en,
  input  logic             cfg_rts_req,
  input  logic [1:0]       cfg_trig_sel,
  input  logic             irq_rts_en,
  input  logic             irq_cts_en,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             rx_stop_seen,
  input  logic             tx_char_start,
  input  logic             tx_char_done,
  input  logic             cts_in_n,
  input  logic             modem_stat_rd,
  output logic             rts_n,
  output logic             tx_permit,
  output logic             irq_flow,
  output logic             stat_rts,
  output logic             stat_cts
);
  import uart_flow_pkg::*;

  logic             auto_rts;
  logic             cts_line;
  logic             rts_up;
  logic [CNT_W-1:0] trig_lvl;

  assign auto_rts = cfg_flow_en && cfg_rts_req;
  assign trig_lvl = CNT_W'(pick_trig(cfg_trig_sel, TRIG_A, TRIG_B, TRIG_C, TRIG_D));

  flow_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(cts_in_n), .dout(cts_line)
  );

  flow_rts_ctrl #(.CNT_W(CNT_W)) u_rts (
    .clk(clk), .rst(rst), .auto_on(auto_rts), .rts_req(cfg_rts_req),
    .rx_count(rx_count), .trig_lvl(trig_lvl), .stop_seen(rx_stop_seen),
    .rts_n(rts_n), .rts_up(rts_up), .stat_rts(stat_rts)
  );

  flow_tx_gate u_gate (
    .clk(clk), .rst(rst), .cts_block(cfg_flow_en && cts_line),
    .char_start(tx_char_start), .char_done(tx_char_done), .tx_permit(tx_permit)
  );

  flow_irq u_irq (
    .clk(clk), .rst(rst), .rts_up(rts_up), .rts_ien(irq_rts_en),
    .cts_line(cts_line), .cts_watch(cfg_flow_en), .cts_ien(irq_cts_en),
    .stat_rd(modem_stat_rd), .irq(irq_flow)
  );

  always_ff @(posedge clk) begin
    if (rst) stat_cts <= 1'b0;
    else     stat_cts <= cfg_flow_en && cts_line;
  end
endmodule

// File: rtl/uart_flow_ctl_chk.sv
module uart_flow_ctl_chk #(
  parameter int FIFO_DEPTH = 16,
  parameter int TRIG_A     = 1,
  parameter int TRIG_B     = 4,
  parameter int TRIG_C     = 8,
  parameter int TRIG_D     = 14,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_flow_en,
  input logic             cfg_rts_req,
  input logic [1:0]       cfg_trig_sel,
  input logic             irq_rts_en,
  input logic             irq_cts_en,
  input logic [CNT_W-1:0] rx_count,
  input logic             rx_stop_seen,
  input logic             tx_char_start,
  input logic             tx_char_done,
  input logic             modem_stat_rd,
  input logic             rts_n,
  input logic             tx_permit,
  input logic             irq_flow,
  input logic             stat_rts,
  input logic             stat_cts
);
  import uart_flow_pkg::*;

  logic [CNT_W-1:0] trig_chk;
  logic             in_char, in_char_nx;

  assign trig_chk   = CNT_W'(pick_trig(cfg_trig_sel, TRIG_A, TRIG_B, TRIG_C, TRIG_D));
  assign in_char_nx = tx_char_start || (in_char && !tx_char_done);

  always_ff @(posedge clk) begin
    if (rst) in_char <= 1'b0;
    else     in_char <= in_char_nx;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (rts_n && tx_permit && !irq_flow && !stat_rts && !stat_cts));

  // R3
  manual_rts_chk: assert property (@(posedge clk) disable iff (rst)
    !(cfg_flow_en && cfg_rts_req) |=> (rts_n == !$past(cfg_rts_req)));

  // R5
  rts_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_flow_en && cfg_rts_req && !rts_n && !(rx_stop_seen && rx_count >= trig_chk))
    |=> !rts_n);

  // R6
  rts_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_flow_en && cfg_rts_req && rts_n && rx_count >= trig_chk) |=> rts_n);

  // R8
  permit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    in_char_nx |=> $stable(tx_permit));

  // R9
  permit_free_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_flow_en && !in_char_nx) |=> tx_permit);

  // R10
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    (!irq_flow && !irq_rts_en && !irq_cts_en) |=> !irq_flow);

  // R12
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (modem_stat_rd && !irq_rts_en && !irq_cts_en) |=> !irq_flow);

  // R13
  stat_off_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_flow_en |=> (!stat_rts && !stat_cts));
endmodule

bind uart_flow_ctl uart_flow_ctl_chk #(
  .FIFO_DEPTH(FIFO_DEPTH), .TRIG_A(TRIG_A), .TRIG_B(TRIG_B),
  .TRIG_C(TRIG_C), .TRIG_D(TRIG_D)
) u_chk (
  .clk(clk), .rst(rst), .cfg_flow_en(cfg_flow_en), .cfg_rts_req(cfg_rts_req),
  .cfg_trig_sel(cfg_trig_sel), .irq_rts_en(irq_rts_en), .irq_cts_en(irq_cts_en),
  .rx_count(rx_count), .rx_stop_seen(rx_stop_seen), .tx_char_start(tx_char_start),
  .tx_char_done(tx_char_done), .modem_stat_rd(modem_stat_rd), .rts_n(rts_n),
  .tx_permit(tx_permit), .irq_flow(irq_flow), .stat_rts(stat_rts), .stat_cts(stat_cts)
);

// File: tb/sim_uart_flow_ctl.sv
module sim_uart_flow_ctl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_flow_en = 0, cfg_rts_req = 0;
  logic [1:0] cfg_trig_sel = 0;
  logic       irq_rts_en = 0, irq_cts_en = 0;
  logic [4:0] rx_count = 0;
  logic       rx_stop_seen = 0, tx_char_start = 0, tx_char_done = 0;
  logic       cts_in_n = 0, modem_stat_rd = 0;
  logic       rts_n, tx_permit, irq_flow, stat_rts, stat_cts;

  int total = 0;
  int bad   = 0;
  bit model_ok = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  uart_flow_ctl u0 (
    .clk(clk), .rst(rst), .cfg_flow_en(cfg_flow_en), .cfg_rts_req(cfg_rts_req),
    .cfg_trig_sel(cfg_trig_sel), .irq_rts_en(irq_rts_en), .irq_cts_en(irq_cts_en),
    .rx_count(rx_count), .rx_stop_seen(rx_stop_seen), .tx_char_start(tx_char_start),
    .tx_char_done(tx_char_done), .cts_in_n(cts_in_n), .modem_stat_rd(modem_stat_rd),
    .rts_n(rts_n), .tx_permit(tx_permit), .irq_flow(irq_flow),
    .stat_rts(stat_rts), .stat_cts(stat_cts)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: one update per rising edge.
  bit m_rts, m_perm, m_irq, m_srts, m_scts;
  bit p_rts, p_cts, m_busy;
  bit cts_hist[$];
  bit cts_prev;

  function automatic int lvl_of(input logic [1:0] c);
    case (c)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_rts = 1; m_perm = 1; m_irq = 0; m_srts = 0; m_scts = 0;
      p_rts = 0; p_cts = 0; m_busy = 0; cts_prev = 0;
      cts_hist = '{0, 0};
      model_ok = 1;
    end else begin
      bit a_rts, a_cts, up, nrts, line, rise, nb;
      int lvl;
      lvl   = lvl_of(cfg_trig_sel);
      a_rts = cfg_flow_en && cfg_rts_req;
      a_cts = cfg_flow_en;
      line  = cts_hist[1];
      rise  = line && !cts_prev;
      up    = a_rts && !m_rts && rx_stop_seen && (int'(rx_count) >= lvl);
      if (!a_rts)                              nrts = !cfg_rts_req;
      else if (up)                             nrts = 1;
      else if (m_rts && int'(rx_count) < lvl)  nrts = 0;
      else                                     nrts = m_rts;
      if (up && irq_rts_en) p_rts = 1; else if (modem_stat_rd) p_rts = 0;
      if (a_cts && irq_cts_en && rise) p_cts = 1; else if (modem_stat_rd) p_cts = 0;
      m_irq = p_rts || p_cts;
      nb = tx_char_start || (m_busy && !tx_char_done);
      if (!nb) m_perm = !(a_cts && line);
      m_busy = nb;
      m_srts = a_rts && nrts;
      m_scts = a_cts && line;
      m_rts  = nrts;
      cts_prev = line;
      cts_hist.push_front(cts_in_n);
      void'(cts_hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (model_ok && !finished) begin
      chk("R5 rts_n", rts_n, m_rts);
      chk("R8 tx_permit", tx_permit, m_perm);
      chk("R11 irq_flow", irq_flow, m_irq);
      chk("R13 stat_rts", stat_rts, m_srts);
      chk("R7 stat_cts", stat_cts, m_scts);
    end
  end

  task automatic nxt(input int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic stop_pulse(input logic [4:0] cnt);
    rx_count = cnt; rx_stop_seen = 1; nxt(); rx_stop_seen = 0;
  endtask

  task automatic rd_pulse();
    modem_stat_rd = 1; nxt(); modem_stat_rd = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    nxt(3);
    // R1 reset state
    chk("R1 rts_n", rts_n, 1); chk("R1 tx_permit", tx_permit, 1);
    chk("R1 irq_flow", irq_flow, 0); chk("R1 stat_rts", stat_rts, 0);
    chk("R1 stat_cts", stat_cts, 0);
    rst = 0;

    // R3 manual control
    cfg_rts_req = 1; nxt(); chk("R3 rts low", rts_n, 0);
    cfg_rts_req = 0; nxt(); chk("R3 rts high", rts_n, 1);

    // R2/R5 automatic RTS, trigger code 01 -> 4
    cfg_flow_en = 1; cfg_rts_req = 1; cfg_trig_sel = 2'b01; rx_count = 3;
    nxt(); chk("R2 auto rts ready", rts_n, 0);
    stop_pulse(3); chk("R4 below level", rts_n, 0);
    rx_count = 4; nxt(2); chk("R5 no stop strobe", rts_n, 0);
    stop_pulse(4);
    chk("R5 rise at stop", rts_n, 1); chk("R13 stat_rts", stat_rts, 1);
    chk("R10 disabled irq", irq_flow, 0);

    // R6 hysteresis
    rx_count = 5; nxt(2); chk("R6 hold high", rts_n, 1);
    rx_count = 3; nxt(); chk("R6 release", rts_n, 0);
    chk("R13 stat_rts low", stat_rts, 0);

    // R10 / R12 RTS interrupt
    irq_rts_en = 1; stop_pulse(4);
    chk("R10 rts irq", irq_flow, 1);
    nxt(); chk("R10 irq held", irq_flow, 1);
    rd_pulse(); chk("R12 read clears", irq_flow, 0);
    rx_count = 0; nxt(); chk("R6 release", rts_n, 0);
    irq_rts_en = 0;

    // R4 remaining codes
    cfg_trig_sel = 2'b11; stop_pulse(13); chk("R4 code11 13", rts_n, 0);
    stop_pulse(14); chk("R4 code11 14", rts_n, 1);
    rx_count = 0; nxt();
    cfg_trig_sel = 2'b00; stop_pulse(1); chk("R4 code00 1", rts_n, 1);
    rx_count = 0; nxt(); chk("R4 code00 release", rts_n, 0);
    cfg_trig_sel = 2'b10; stop_pulse(7); chk("R4 code10 7", rts_n, 0);
    stop_pulse(8); chk("R4 code10 8", rts_n, 1);
    rx_count = 0; nxt();

    // R12 event in the same cycle as a read
    irq_rts_en = 1; cfg_trig_sel = 2'b01;
    rx_count = 4; rx_stop_seen = 1; modem_stat_rd = 1; nxt();
    rx_stop_seen = 0; modem_stat_rd = 0;
    chk("R12 set wins", irq_flow, 1);
    rd_pulse(); chk("R12 clear", irq_flow, 0);
    rx_count = 0; irq_rts_en = 0; nxt();

    // R7 / R11 CTS path
    irq_cts_en = 1; cts_in_n = 1;
    nxt(); chk("R7 stage1", stat_cts, 0);
    nxt(); chk("R7 stage2", stat_cts, 0); chk("R7 permit early", tx_permit, 1);
    nxt(); chk("R7 stage3", stat_cts, 1); chk("R8 idle block", tx_permit, 0);
    chk("R11 cts irq", irq_flow, 1);
    rd_pulse(); chk("R12 cts clear", irq_flow, 0);
    cts_in_n = 0; nxt(3); chk("R8 idle resume", tx_permit, 1);
    chk("R11 no irq on fall", irq_flow, 0);
    irq_cts_en = 0;

    // R8 character in progress
    tx_char_start = 1; nxt(); tx_char_start = 0;
    cts_in_n = 1; nxt(4); chk("R8 mid char", tx_permit, 1);
    tx_char_done = 1; nxt(); tx_char_done = 0;
    chk("R8 boundary", tx_permit, 0);
    cts_in_n = 0; nxt(3); chk("R8 resume", tx_permit, 1);

    // R9 disabled CTS
    cfg_flow_en = 0; cts_in_n = 1; nxt(4);
    chk("R9 no gating", tx_permit, 1); chk("R13 stat_cts off", stat_cts, 0);

    // R2 CTS only
    cfg_flow_en = 1; cfg_rts_req = 0; irq_rts_en = 1; nxt(3);
    chk("R2 rts manual", rts_n, 1); chk("R2 cts active", tx_permit, 0);
    stop_pulse(16); chk("R2 no rts irq", irq_flow, 0);
    chk("R13 stat_rts off", stat_rts, 0);
    rx_count = 0; irq_rts_en = 0; cts_in_n = 0; nxt(3);

    // Mixed phase, compared every cycle against the model
    begin
      bit bsy = 0;
      int left = 0;
      for (int i = 0; i < 4000; i++) begin
        rx_stop_seen = 0; tx_char_start = 0; tx_char_done = 0; modem_stat_rd = 0;
        if ($urandom_range(0, 1) == 1) begin
          if ($urandom_range(0, 1) == 1 && rx_count < 16) rx_count = rx_count + 1;
          else if (rx_count > 0) rx_count = rx_count - 1;
        end
        if ($urandom_range(0, 7) == 0) rx_stop_seen = 1;
        if ($urandom_range(0, 15) == 0) cts_in_n = ~cts_in_n;
        if ($urandom_range(0, 9) == 0) modem_stat_rd = 1;
        if ($urandom_range(0, 63) == 0) irq_rts_en = ~irq_rts_en;
        if ($urandom_range(0, 63) == 0) irq_cts_en = ~irq_cts_en;
        if ($urandom_range(0, 199) == 0) cfg_flow_en = ~cfg_flow_en;
        if ($urandom_range(0, 149) == 0) cfg_rts_req = ~cfg_rts_req;
        if ($urandom_range(0, 299) == 0) cfg_trig_sel = 2'($urandom_range(0, 3));
        if (bsy) begin
          left--;
          if (left == 0) begin tx_char_done = 1; bsy = 0; end
        end else if (tx_permit && $urandom_range(0, 3) == 0) begin
          tx_char_start = 1; bsy = 1; left = $urandom_range(3, 10);
        end
        nxt();
      end
      rx_stop_seen = 0; tx_char_start = 0; tx_char_done = 0; modem_stat_rd = 0;
    end
    nxt(2);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule